// File: doc/BRIEF.md
# RTC Interrupt Flag Unit

This block turns the timing events of a real-time clock into interrupt status flags. It has three sources. The first is a periodic event, made by dividing a base tick by a power of two that a 4-bit rate field selects. The second is an alarm event, raised when the live seconds, minutes and hours match three alarm bytes at the end of a one-second update. The third is an update-ended event, raised at every one-second update. Each event sets its own flag, whether or not that source is enabled.

A summary request bit and the interrupt output are active when at least one flag is set and that flag's enable bit is also set. Software reads the flags through an 8-bit status value. A read strobe clears every flag at the next clock edge. An event that arrives in the same cycle as the read is kept, so the next read reports it. An optional square-wave output follows the selected divider stage. The timekeeping counters are not part of this block.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, `stat_o`, `irq_o` and `sqw_o` are all 0.
- R2: For a rate select r in 1..15, the periodic flag (`stat_o` bit 6) is set once every 2^r base ticks. The first setting follows the 2^r-th tick counted from reset. The flag is visible in the cycle after that tick.
- R3: With a rate select of 0, no periodic event occurs and `sqw_o` stays 0.
- R4: When `upd_done_i` is high and all three time fields match their alarm bytes, the alarm flag (`stat_o` bit 5) is set in the following cycle.
- R5: An alarm byte whose bits 7:6 are both 1 matches any value of its time field.
- R6: Every `upd_done_i` pulse sets the update-ended flag (`stat_o` bit 4) in the following cycle.
- R7: `stat_o` bits 3:0 always read 0.
- R8: `stat_o` bit 7 and `irq_o` are 1 exactly when some flag is set and its enable is set. The pairs are periodic with `pie_en_i`, alarm with `aie_en_i`, and update-ended with `uie_en_i`.
- R9: A flag is set by its event even while its enable is clear. It then does not drive bit 7 or `irq_o`.
- R10: While `stat_rd_i` is high, `stat_o` shows the current flags. At the next edge, every flag is cleared unless an event sets it in that same cycle.
- R11: An event that coincides with a status read sets its flag after the clear, so the next read reports it.
- R12: When `sqw_en_i` is high and the rate select r is nonzero, `sqw_o` equals bit r-1 of a free-running count of base ticks. Otherwise `sqw_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick pulse for the periodic divider |
| rate_sel_i | input | 4 | Periodic rate select, 0 = off |
| upd_done_i | input | 1 | One-cycle pulse at the end of each one-second update |
| sec_i | input | 8 | Live seconds |
| min_i | input | 8 | Live minutes |
| hour_i | input | 8 | Live hours |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hour_i | input | 8 | Alarm hours byte |
| pie_en_i | input | 1 | Periodic interrupt enable |
| aie_en_i | input | 1 | Alarm interrupt enable |
| uie_en_i | input | 1 | Update-ended interrupt enable |
| sqw_en_i | input | 1 | Square-wave output enable |
| stat_rd_i | input | 1 | Status read strobe, clears flags at the next edge |
| stat_o | output | 8 | Status: bit 7 summary, bit 6 periodic, bit 5 alarm, bit 4 update-ended, bits 3:0 zero |
| irq_o | output | 1 | Interrupt request, active high |
| sqw_o | output | 1 | Square-wave output |

## Verification
Random stimulus mixes sparse and dense base ticks with rate selects that mostly fall in 0..4, so periodic flags occur often. Occasional large rates check that the divider tap is picked correctly. Update pulses come with time values that sometimes equal the alarm bytes, sometimes differ in one field only, and sometimes face wildcard bytes. This separates a full match from a partial match and from a match through the wildcard. Enables toggle on their own, which separates flag setting from request gating. Read strobes land both on quiet cycles and on event cycles, which separates a plain clear from a clear that must keep a coinciding event.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int STAT_W   = 8;
  localparam int IRQF_BIT = 7;
  localparam int PF_BIT   = 6;
  localparam int AF_BIT   = 5;
  localparam int UF_BIT   = 4;
  localparam int NUM_SRC  = 3;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } irq_src_t;
endpackage

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int SEL_W = 4,
  parameter int DIV_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             sqw_en_i,
  output logic             evt_o,
  output logic             sqw_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] tap;

  // mask holds the low r bits of the prescaler
  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign mask[g] = (int'(rate_sel_i) > g);
  end

  assign tap = mask & ~(mask >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign evt_o = tick_i && (rate_sel_i != '0) && ((cnt_q & mask) == mask);
  assign sqw_o = sqw_en_i && |(cnt_q & tap);

  // R3
  rate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == '0) |-> (!evt_o && !sqw_o));
  // R2
  evt_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> tick_i);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FIELD_W = 8,
  parameter int NUM_F   = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_i,
  input  logic [NUM_F-1:0][FIELD_W-1:0] time_i,
  input  logic [NUM_F-1:0][FIELD_W-1:0] alarm_i,
  output logic                          evt_o
);
  logic [NUM_F-1:0] hit;
  logic [NUM_F-1:0] wild;

  for (genvar g = 0; g < NUM_F; g++) begin : g_field
    assign wild[g] = &alarm_i[g][FIELD_W-1 -: 2];
    assign hit[g]  = wild[g] || (alarm_i[g] == time_i[g]);
  end

  assign evt_o = upd_i && &hit;

  // R5
  wildcard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && &wild) |-> evt_o);
  // R4
  alarm_on_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> upd_i);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_src_t evt_i,
  input  irq_src_t en_i,
  input  logic     rd_i,
  output irq_src_t flags_o,
  output logic     irqf_o
);
  irq_src_t flags_q;

  // a coinciding event survives the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (rd_i ? irq_src_t'('0) : flags_q) | evt_i;
  end

  assign flags_o = flags_q;
  assign irqf_o  = |(flags_q & en_i);

  // R10
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && evt_i == '0) |=> (flags_q == '0));
  // R11
  evt_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.uf |=> flags_q.uf);
  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && flags_q.pf) |=> flags_q.pf);
  // R8
  no_flag_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == '0) |-> !irqf_o);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [SEL_W-1:0]   rate_sel_i,
  input  logic               upd_done_i,
  input  logic [FIELD_W-1:0] sec_i,
  input  logic [FIELD_W-1:0] min_i,
  input  logic [FIELD_W-1:0] hour_i,
  input  logic [FIELD_W-1:0] alm_sec_i,
  input  logic [FIELD_W-1:0] alm_min_i,
  input  logic [FIELD_W-1:0] alm_hour_i,
  input  logic               pie_en_i,
  input  logic               aie_en_i,
  input  logic               uie_en_i,
  input  logic               sqw_en_i,
  input  logic               stat_rd_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic               irq_o,
  output logic               sqw_o
);
  irq_src_t evt, en, flags;
  logic     irqf;

  rtc_periodic_gen #(.SEL_W(SEL_W)) u_per (
    .clk_i, .rst_ni, .tick_i, .rate_sel_i, .sqw_en_i,
    .evt_o(evt.pf), .sqw_o
  );

  rtc_alarm_match #(.FIELD_W(FIELD_W), .NUM_F(3)) u_alm (
    .clk_i, .rst_ni,
    .upd_i  (upd_done_i),
    .time_i ({hour_i, min_i, sec_i}),
    .alarm_i({alm_hour_i, alm_min_i, alm_sec_i}),
    .evt_o  (evt.af)
  );

  assign evt.uf = upd_done_i;
  assign en     = '{pf: pie_en_i, af: aie_en_i, uf: uie_en_i};

  rtc_irq_flags u_flg (
    .clk_i, .rst_ni, .evt_i(evt), .en_i(en), .rd_i(stat_rd_i),
    .flags_o(flags), .irqf_o(irqf)
  );

  always_comb begin
    stat_o           = '0;
    stat_o[IRQF_BIT] = irqf;
    stat_o[PF_BIT]   = flags.pf;
    stat_o[AF_BIT]   = flags.af;
    stat_o[UF_BIT]   = flags.uf;
  end

  assign irq_o = irqf;

  // R6
  uf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> stat_o[UF_BIT]);
endmodule

// File: tb/rtc_irq_unit_bench.sv
`timescale 1ns/1ps
module rtc_irq_unit_bench;
  logic clk = 0, rst_n = 0;
  logic tick = 0, upd = 0, rd = 0;
  logic [3:0] rate = 0;
  logic [7:0] sec = 0, mn = 0, hr = 0, asec = 0, amin = 0, ahr = 0;
  logic pie = 0, aie = 0, uie = 0, sqwe = 0;
  logic [7:0] stat;
  logic irq, sqw;

  int total = 0, bad = 0;
  logic [14:0] mcnt = 0;
  logic [2:0] mflags = 0; // {pf,af,uf}

  always #2 clk = ~clk;

  rtc_irq_unit u_rtc_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_sel_i(rate),
    .upd_done_i(upd), .sec_i(sec), .min_i(mn), .hour_i(hr),
    .alm_sec_i(asec), .alm_min_i(amin), .alm_hour_i(ahr),
    .pie_en_i(pie), .aie_en_i(aie), .uie_en_i(uie), .sqw_en_i(sqwe),
    .stat_rd_i(rd), .stat_o(stat), .irq_o(irq), .sqw_o(sqw)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic fmatch(logic [7:0] t, logic [7:0] a);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  function automatic logic [14:0] fmask(logic [3:0] r);
    return 15'((32'd1 << r) - 1);
  endfunction

  // one cycle: inputs already set at negedge, model then compare after edge
  task automatic step();
    logic pe, ae;
    logic [14:0] m;
    m  = fmask(rate);
    pe = tick && rate != 0 && ((mcnt & m) == m);
    ae = upd && fmatch(sec, asec) && fmatch(mn, amin) && fmatch(hr, ahr);
    if (tick) mcnt = mcnt + 1'b1;
    mflags = (rd ? 3'b000 : mflags) | {pe, ae, upd};
    @(posedge clk); #1;
    begin
      logic ie, es;
      ie = |(mflags & {pie, aie, uie});
      es = sqwe && rate != 0 && mcnt[rate - 4'd1];
      chk("R2 PF", {7'b0, stat[6]}, {7'b0, mflags[2]});
      chk("R4 AF", {7'b0, stat[5]}, {7'b0, mflags[1]});
      chk("R6 UF", {7'b0, stat[4]}, {7'b0, mflags[0]});
      chk("R7 low bits", {4'b0, stat[3:0]}, 8'h00);
      chk("R8 IRQF", {7'b0, stat[7]}, {7'b0, ie});
      chk("R8 irq_o", {7'b0, irq}, {7'b0, ie});
      chk("R12 sqw", {7'b0, sqw}, {7'b0, es});
    end
    @(negedge clk);
    tick = 0; upd = 0; rd = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 stat", stat, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 sqw", {7'b0, sqw}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R5 wildcard alarm, enable off -> R9 flag set, no irq
    asec = 8'hC0; amin = 8'hFF; ahr = 8'hC5; sec = 8'h37; mn = 8'h12; hr = 8'h09;
    upd = 1; step();
    chk("R5 wildcard AF", {7'b0, stat[5]}, 8'h01);
    chk("R9 no irq when disabled", {7'b0, irq}, 8'h00);
    aie = 1; #1;
    chk("R8 enable raises irq", {7'b0, irq}, 8'h01);

    // R10 read with no event clears
    rd = 1; step();
    chk("R10 cleared", stat, 8'h00);

    // R11 read coinciding with update keeps UF
    upd = 1; step();
    rd = 1; upd = 1; asec = 8'h01; step();
    chk("R11 UF kept", stat & 8'h70, 8'h10);
    rd = 1; step();

    // R3 rate 0: no PF, no square wave
    rate = 0; sqwe = 1; pie = 1;
    for (int i = 0; i < 40; i++) begin tick = 1; step(); end
    chk("R3 no PF", {7'b0, stat[6]}, 8'h00);

    // R2 rate 1: PF after two ticks
    rd = 1; step();
    rate = 1;
    for (int i = 0; i < 6; i++) begin tick = 1; step(); end

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int sel;
      tick = ($urandom % 2) == 0;
      if ($urandom % 64 == 0) begin
        sel = $urandom % 8;
        rate = (sel < 6) ? 4'($urandom % 5) : 4'($urandom % 16);
      end
      if ($urandom % 16 == 0) begin
        pie = 1'($urandom); aie = 1'($urandom); uie = 1'($urandom); sqwe = 1'($urandom);
      end
      upd = ($urandom % 6) == 0;
      if (upd) begin
        sel = $urandom % 4;
        sec = 8'($urandom % 60); mn = 8'($urandom % 60); hr = 8'($urandom % 24);
        case (sel)
          0: begin asec = sec; amin = mn; ahr = hr; end
          1: begin asec = sec; amin = mn; ahr = hr ^ 8'h01; end
          2: begin asec = 8'hC0 | 8'($urandom); amin = mn; ahr = 8'hC0; end
          default: begin asec = 8'($urandom); amin = 8'($urandom); ahr = 8'($urandom); end
        endcase
      end
      rd = ($urandom % 5) == 0;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule